// File: doc/BRIEF.md
# VITC read-line scan controller

This block decides, field by field, which video line each of two redundant vertical-interval time code readers samples. An external bit decoder does the actual code extraction; this controller only opens a per-line sample gate for each reader, judges the decoder's per-line verdict, and keeps two status flags per reader. Each reader is programmed with an enable bit and a 5-bit line code. A code from 0 to 30 pins the reader to one line. The all-ones code puts the reader into a search that tries one candidate line per field.

The line position comes from two strobes. A field-start strobe opens line 1 of a field, and each line-start strobe advances to the next line. A line-end strobe marks the moment the decoder's "complete" and "CRC good" results are valid for the line that is ending. The second reader can follow the first. When both search, the second waits until the first has found code and then searches the lines after it. When the first is pinned, the second starts right after the pinned line.

Top module: `vitc_line_scan`

## Requirements
- R1: A reader with enable (cfg_data bit 5) set and line code c from 0 to 30 (cfg_data bits 4:0) gates exactly line c+10 of every field, starting with the field opened after the write. Its rd_line output reports c+10 and its rd_settled output is 1.
- R2: A disabled reader never raises its gate. Its rd_line is 0 and its rd_settled is 1, and both status flags keep their values.
- R3: Line code 31 selects search mode. When reader 0 searches, it tries line 10 in the first field after the write and then tries the next higher line in each following field, one candidate per field. rd_settled stays 0 while it searches.
- R4: A line is qualified when dec_done and dec_crc_ok are both 1 at its line_end. A searching reader stops at the first qualified candidate and gates that line in every later field until it is rewritten. It reports that line on rd_line with rd_settled at 1.
- R5: No search tries any line beyond 41. After line 41 fails, the reader gates nothing and reports rd_line 0 with rd_settled 0.
- R6: When both readers search, reader 1 gates nothing until the field that follows reader 0's lock. It then searches upward starting at reader 0's line plus one.
- R7: A searching reader 1 begins at reader 0's pinned line plus one in the first field after the write, whatever reader 0's decoder reports. If reader 0 is disabled, reader 1 begins at line 10.
- R8: At the line_end of a gated line, no_code becomes NOT dec_done and crc_err becomes NOT (dec_done AND dec_crc_ok). At every other time, outside a write, both flags hold.
- R9: A write to a reader sets both of its flags to 1 on the next cycle and restarts its selection at the next field start.
- R10: A reader raises its gate for at most one line in any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Reader addressed by the write (0 or 1) |
| cfg_data | input | 6 | Bit 5 enable, bits 4:0 line code (31 = search) |
| field_start | input | 1 | Opens line 1 of a new field |
| line_start | input | 1 | Advances to the next line |
| line_end | input | 1 | End of the current line; decoder results valid |
| dec_done | input | 2 | Per reader: all code bits arrived before line end |
| dec_crc_ok | input | 2 | Per reader: code CRC matched |
| rd_gate | output | 2 | Per reader: sample gate for the current line |
| rd_line_a | output | 6 | Line held or tried by reader 0, 0 when none |
| rd_line_b | output | 6 | Line held or tried by reader 1, 0 when none |
| rd_settled | output | 2 | Per reader: line is final (pinned, found, or disabled) |
| crc_err | output | 2 | Per reader: last sampled line lacked a good CRC |
| no_code | output | 2 | Per reader: last sampled line ended before all bits arrived |

## Verification
On every cycle, the assertions check several properties. Any gate lines up with the line counter. A gate rises at most once per field. The flags move only at a sampled line end or a write, and a write leaves both flags at 1. no_code never stands without crc_err. A settled reader's line stays put, and any reported line stays inside the 10 to 41 window. The search order, the lock onto the first qualified line, the wait of the second reader for the first, its start line after a pinned or found line, and the give-up after line 41 span many fields. Only the bench's field-by-field scenarios can show these behaviours.

// File: rtl/vitc_scan_pkg.sv
package vitc_scan_pkg;
  localparam int CODE_W     = 5;
  localparam int CFG_W      = CODE_W + 1;
  localparam int LN_W       = 6;
  localparam int LINE_OFS   = 10;
  localparam int SCAN_FIRST = 10;
  localparam int SCAN_LAST  = 41;
  localparam logic [CODE_W-1:0] SCAN_CODE = '1;

  typedef enum logic [2:0] {
    RS_ARMED,
    RS_FIXED,
    RS_SEARCH,
    RS_LOCKED,
    RS_SPENT
  } rd_state_e;

  // Line picked by a fixed code.
  function automatic logic [LN_W-1:0] fixed_line(input logic [CODE_W-1:0] code);
    return LN_W'(code) + LN_W'(LINE_OFS);
  endfunction

  function automatic logic is_scan(input logic [CODE_W-1:0] code);
    return code == SCAN_CODE;
  endfunction

  function automatic logic qualified(input logic done, input logic ok);
    return done && ok;
  endfunction

  // Start line of a follower: upstream line + 1, or the window start if upstream holds none.
  function automatic logic [LN_W-1:0] follow_line(input logic [LN_W-1:0] held);
    return (held == '0) ? LN_W'(SCAN_FIRST) : held + LN_W'(1);
  endfunction

  function automatic logic past_window(input logic [LN_W-1:0] ln);
    return ln > LN_W'(SCAN_LAST);
  endfunction
endpackage

// File: rtl/vitc_line_counter.sv
module vitc_line_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_start,
  input  logic             line_start,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (field_start) begin
      cnt <= CNT_W'(1);
    end else if (line_start && (cnt != CNT_MAX)) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/vitc_chain_link.sv
module vitc_chain_link
  import vitc_scan_pkg::*;
(
  input  logic            up_settled,
  input  logic [LN_W-1:0] up_line,
  output logic            go,
  output logic [LN_W-1:0] start_line
);
  assign go         = up_settled;
  assign start_line = follow_line(up_line);
endmodule

// File: rtl/vitc_scan_reader.sv
module vitc_scan_reader
  import vitc_scan_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             field_start,
  input  logic             smp,
  input  logic [CNT_W-1:0] line_cnt,
  input  logic             dec_done,
  input  logic             dec_ok,
  input  logic             chain_go,
  input  logic [LN_W-1:0]  chain_start,
  output logic             gate,
  output logic [LN_W-1:0]  line_o,
  output logic             settled_o,
  output logic             crc_err_o,
  output logic             no_code_o
);
  logic              en_q;
  logic [CODE_W-1:0] code_q;
  rd_state_e         st_q;
  logic [LN_W-1:0]   cand_q;
  logic              tried_q;
  logic              crc_q;
  logic              noc_q;

  logic            scan;
  logic            live;
  logic [LN_W-1:0] target;
  logic            qual;

  assign scan   = is_scan(code_q);
  assign target = (st_q == RS_FIXED) ? fixed_line(code_q) : cand_q;
  assign live   = (st_q == RS_FIXED) || (st_q == RS_LOCKED) ||
                  ((st_q == RS_SEARCH) && !tried_q);
  assign gate   = en_q && live && (line_cnt == CNT_W'(target));
  assign qual   = qualified(dec_done, dec_ok);

  always_comb begin
    if (!en_q) begin
      line_o = '0;
    end else if (!scan) begin
      line_o = fixed_line(code_q);
    end else if ((st_q == RS_SEARCH) || (st_q == RS_LOCKED)) begin
      line_o = cand_q;
    end else begin
      line_o = '0;
    end
  end

  assign settled_o = !en_q || !scan || (st_q == RS_LOCKED);
  assign crc_err_o = crc_q;
  assign no_code_o = noc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      code_q  <= '0;
      st_q    <= RS_ARMED;
      cand_q  <= '0;
      tried_q <= 1'b0;
      crc_q   <= 1'b1;
      noc_q   <= 1'b1;
    end else if (wr_hit) begin
      en_q    <= wr_data[CFG_W-1];
      code_q  <= wr_data[CODE_W-1:0];
      st_q    <= RS_ARMED;
      cand_q  <= '0;
      tried_q <= 1'b0;
      crc_q   <= 1'b1;
      noc_q   <= 1'b1;
    end else if (smp) begin
      crc_q <= !qual;
      noc_q <= !dec_done;
      if (st_q == RS_SEARCH) begin
        if (qual) begin
          st_q <= RS_LOCKED;
        end else begin
          tried_q <= 1'b1;
        end
      end
    end else if (field_start) begin
      case (st_q)
        RS_ARMED: begin
          if (en_q) begin
            if (!scan) begin
              st_q <= RS_FIXED;
            end else if (chain_go) begin
              if (past_window(chain_start)) begin
                st_q <= RS_SPENT;
              end else begin
                st_q   <= RS_SEARCH;
                cand_q <= chain_start;
              end
            end
          end
        end
        RS_SEARCH: begin
          if (tried_q) begin
            tried_q <= 1'b0;
            if (cand_q >= LN_W'(SCAN_LAST)) begin
              st_q <= RS_SPENT;
            end else begin
              cand_q <= cand_q + LN_W'(1);
            end
          end
        end
        default: begin
        end
      endcase
    end
  end
endmodule

// File: rtl/vitc_line_scan.sv
module vitc_line_scan
  import vitc_scan_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [5:0]  cfg_data,
  input  logic        field_start,
  input  logic        line_start,
  input  logic        line_end,
  input  logic [1:0]  dec_done,
  input  logic [1:0]  dec_crc_ok,
  output logic [1:0]  rd_gate,
  output logic [5:0]  rd_line_a,
  output logic [5:0]  rd_line_b,
  output logic [1:0]  rd_settled,
  output logic [1:0]  crc_err,
  output logic [1:0]  no_code
);
  localparam int NRD = 2;

  logic [CNT_W-1:0] line_cnt;
  logic [NRD-1:0]   wr_hit;
  logic [NRD-1:0]   smp;
  logic [NRD-1:0]   gate_w;
  logic [NRD-1:0]   settled_w;
  logic [LN_W-1:0]  line_w     [NRD];
  logic             chain_go_w [NRD];
  logic [LN_W-1:0]  chain_ln_w [NRD];

  vitc_line_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .line_start  (line_start),
    .cnt         (line_cnt)
  );

  assign smp = gate_w & {NRD{line_end}};

  for (genvar gi = 0; gi < NRD; gi++) begin : g_rd
    assign wr_hit[gi] = cfg_we && (cfg_sel == gi[0]);

    if (gi == 0) begin : g_head
      assign chain_go_w[gi] = 1'b1;
      assign chain_ln_w[gi] = LN_W'(SCAN_FIRST);
    end else begin : g_follow
      vitc_chain_link u_link (
        .up_settled (settled_w[gi-1]),
        .up_line    (line_w[gi-1]),
        .go         (chain_go_w[gi]),
        .start_line (chain_ln_w[gi])
      );
    end

    vitc_scan_reader #(.CNT_W(CNT_W)) u_reader (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_hit      (wr_hit[gi]),
      .wr_data     (cfg_data),
      .field_start (field_start),
      .smp         (smp[gi]),
      .line_cnt    (line_cnt),
      .dec_done    (dec_done[gi]),
      .dec_ok      (dec_crc_ok[gi]),
      .chain_go    (chain_go_w[gi]),
      .chain_start (chain_ln_w[gi]),
      .gate        (gate_w[gi]),
      .line_o      (line_w[gi]),
      .settled_o   (settled_w[gi]),
      .crc_err_o   (crc_err[gi]),
      .no_code_o   (no_code[gi])
    );
  end

  assign rd_gate    = gate_w;
  assign rd_settled = settled_w;
  assign rd_line_a  = line_w[0];
  assign rd_line_b  = line_w[1];
endmodule

// File: rtl/vitc_line_scan_chk.sv
module vitc_line_scan_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             field_start,
  input logic [1:0]       wr_hit,
  input logic [1:0]       smp,
  input logic [CNT_W-1:0] line_cnt,
  input logic [1:0]       rd_gate,
  input logic [1:0]       rd_settled,
  input logic [5:0]       rd_line_a,
  input logic [5:0]       rd_line_b,
  input logic [1:0]       crc_err,
  input logic [1:0]       no_code
);
  logic [5:0] ln [2];
  logic [1:0] gate_q;
  logic [1:0] rises [2];

  assign ln[0] = rd_line_a;
  assign ln[1] = rd_line_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q   <= '0;
      rises[0] <= '0;
      rises[1] <= '0;
    end else begin
      gate_q <= rd_gate;
      for (int i = 0; i < 2; i++) begin
        if (field_start) begin
          rises[i] <= '0;
        end else if (rd_gate[i] && !gate_q[i] && (rises[i] != 2'd3)) begin
          rises[i] <= rises[i] + 2'd1;
        end
      end
    end
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_chk
    AST_GATE_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_gate[gi] |-> (line_cnt == CNT_W'(ln[gi])));  // R1
    AST_ONE_GATE_PER_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_gate[gi] && !gate_q[gi]) |-> (rises[gi] == 2'd0));  // R10
    AST_WRITE_RAISES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[gi] |=> (crc_err[gi] && no_code[gi]));  // R9
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit[gi] && !smp[gi]) |=> ($stable(crc_err[gi]) && $stable(no_code[gi])));  // R8
    AST_NOCODE_MEANS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      no_code[gi] |-> crc_err[gi]);  // R8
    AST_SETTLED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_settled[gi] && !wr_hit[gi]) |=> (rd_settled[gi] && $stable(ln[gi])));  // R4
    AST_LINE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ln[gi] != 6'd0) |-> ((ln[gi] >= 6'd10) && (ln[gi] <= 6'd41)));  // R5
  end
endmodule

bind vitc_line_scan vitc_line_scan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .field_start (field_start),
  .wr_hit      (wr_hit),
  .smp         (smp),
  .line_cnt    (line_cnt),
  .rd_gate     (rd_gate),
  .rd_settled  (rd_settled),
  .rd_line_a   (rd_line_a),
  .rd_line_b   (rd_line_b),
  .crc_err     (crc_err),
  .no_code     (no_code)
);

// File: tb/vitc_line_scan_tb.sv
module vitc_line_scan_tb;
  localparam int CLK_PER = 10;
  localparam int LINES   = 45;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [5:0] cfg_data = '0;
  logic       field_start = 1'b0;
  logic       line_start = 1'b0;
  logic       line_end = 1'b0;
  logic [1:0] dec_done = '0;
  logic [1:0] dec_crc_ok = '0;
  logic [1:0] rd_gate;
  logic [5:0] rd_line_a;
  logic [5:0] rd_line_b;
  logic [1:0] rd_settled;
  logic [1:0] crc_err;
  logic [1:0] no_code;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] ok_m [2];
  logic [63:0] done_m [2];
  int got_line [2];
  int got_cnt [2];
  logic [1:0] probe_crc;
  logic [1:0] probe_noc;

  vitc_line_scan u_dut (
    .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
    .cfg_data (cfg_data), .field_start (field_start), .line_start (line_start),
    .line_end (line_end), .dec_done (dec_done), .dec_crc_ok (dec_crc_ok),
    .rd_gate (rd_gate), .rd_line_a (rd_line_a), .rd_line_b (rd_line_b),
    .rd_settled (rd_settled), .crc_err (crc_err), .no_code (no_code)
  );

  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  // Expected tried/held line of a search starting at 'start' in field k; good=0 means no qualified line.
  function automatic int exp_scan(input int start, input int good, input int k);
    int l;
    l = start + k;
    if (good != 0 && l >= good) return good;
    if (l > 41) return 0;
    return l;
  endfunction

  function automatic int line_of(input int i);
    return (i == 0) ? int'(rd_line_a) : int'(rd_line_b);
  endfunction

  task automatic wr_cfg(input int sel, input bit en, input int code);
    cfg_we   = 1'b1;
    cfg_sel  = sel[0];
    cfg_data = {en, code[4:0]};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_field(input int probe_ln);
    for (int i = 0; i < 2; i++) begin
      got_line[i] = 0;
      got_cnt[i]  = 0;
    end
    for (int ln = 1; ln <= LINES; ln++) begin
      if (ln == 1) field_start = 1'b1; else line_start = 1'b1;
      @(negedge clk);
      field_start = 1'b0;
      line_start  = 1'b0;
      for (int i = 0; i < 2; i++) begin
        if (rd_gate[i]) begin
          got_line[i] = ln;
          got_cnt[i]++;
        end
      end
      if (ln == probe_ln) begin
        probe_crc = crc_err;
        probe_noc = no_code;
      end
      line_end   = 1'b1;
      dec_done   = {done_m[1][ln], done_m[0][ln]};
      dec_crc_ok = {ok_m[1][ln], ok_m[0][ln]};
      @(negedge clk);
      line_end   = 1'b0;
      dec_done   = '0;
      dec_crc_ok = '0;
    end
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int code;
    int ga;
    int gb;
    int lf;
    int nf;
    void'($urandom(32'd20240611));
    ok_m[0] = '0; ok_m[1] = '0;
    done_m[0] = '1; done_m[1] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state: both readers disabled
    chk("R2 reset gate", int'(rd_gate), 0);
    chk("R2 reset settled", int'(rd_settled), 3);
    chk("R2 reset line a", int'(rd_line_a), 0);
    chk("R9 reset crc_err", int'(crc_err), 3);
    chk("R9 reset no_code", int'(no_code), 3);

    // R1: fixed lines, directed ends plus random codes
    for (int t = 0; t < 5; t++) begin
      code = (t == 0) ? 0 : (t == 1) ? 30 : rnd(0, 30);
      wr_cfg(0, 1'b1, code);
      ok_m[0] = 64'd1 << (code + 10);
      run_field(0);
      chk("R1 fixed gated line", got_line[0], code + 10);
      chk("R10 fixed one gate", got_cnt[0], 1);
      chk("R1 fixed rd_line", int'(rd_line_a), code + 10);
      chk("R8 good flags crc", int'(crc_err[0]), 0);
      chk("R8 good flags noc", int'(no_code[0]), 0);
      chk("R2 disabled b no gate", got_cnt[1], 0);
    end

    // R8: flag updates and hold through the field
    wr_cfg(0, 1'b1, 5);
    ok_m[0] = 64'd1 << 15;
    run_field(0);
    chk("R8 ok crc", int'(crc_err[0]), 0);
    done_m[0] = ~(64'd1 << 15);
    run_field(14);
    chk("R8 hold crc before line", int'(probe_crc[0]), 0);
    chk("R8 hold noc before line", int'(probe_noc[0]), 0);
    chk("R8 framing crc", int'(crc_err[0]), 1);
    chk("R8 framing noc", int'(no_code[0]), 1);
    done_m[0] = '1;
    ok_m[0]   = '0;
    run_field(0);
    chk("R8 crc bad crc", int'(crc_err[0]), 1);
    chk("R8 crc bad noc", int'(no_code[0]), 0);
    ok_m[0] = 64'd1 << 15;
    run_field(0);
    chk("R8 recover crc", int'(crc_err[0]), 0);
    wr_cfg(0, 1'b1, 5);
    chk("R9 write sets crc", int'(crc_err[0]), 1);
    chk("R9 write sets noc", int'(no_code[0]), 1);

    // R2: disabled reader ignores a good line
    wr_cfg(0, 1'b0, 5);
    run_field(0);
    chk("R2 disabled no gate", got_cnt[0], 0);
    chk("R2 disabled flags", int'(crc_err[0]), 1);
    chk("R2 disabled line", int'(rd_line_a), 0);

    // R3/R4: reader 0 search with a random good line
    for (int t = 0; t < 4; t++) begin
      ga = (t == 0) ? 10 : (t == 1) ? 41 : rnd(11, 40);
      wr_cfg(1, 1'b0, 0);
      wr_cfg(0, 1'b1, 31);
      ok_m[0] = (64'd1 << ga) | (64'd1 << 9);
      nf = ga - 10 + 3;
      for (int k = 0; k < nf; k++) begin
        run_field(0);
        chk((10 + k < ga) ? "R3 search step" : "R4 locked line",
            got_line[0], exp_scan(10, ga, k));
        chk("R10 search one gate", got_cnt[0], 1);
        if (10 + k < ga) chk("R3 unsettled", int'(rd_settled[0]), 0);
      end
      chk("R4 settled", int'(rd_settled[0]), 1);
      chk("R4 rd_line", int'(rd_line_a), ga);
      chk("R4 flags", int'(crc_err[0]) + int'(no_code[0]), 0);
    end

    // R5: search without any good line gives up after 41
    wr_cfg(0, 1'b1, 31);
    ok_m[0] = 64'd1 << 42;
    for (int k = 0; k < 34; k++) begin
      run_field(0);
      chk("R5 exhaust sequence", got_line[0], exp_scan(10, 0, k));
    end
    chk("R5 spent line", int'(rd_line_a), 0);
    chk("R5 spent settled", int'(rd_settled[0]), 0);

    // R9: rewrite mid-search restarts at line 10
    ok_m[0] = '0;
    wr_cfg(0, 1'b1, 31);
    for (int k = 0; k < 3; k++) run_field(0);
    chk("R3 pre-restart line", got_line[0], 12);
    wr_cfg(0, 1'b1, 31);
    run_field(0);
    chk("R9 restart at 10", got_line[0], 10);

    // R7: reader 1 follows a pinned reader 0 that never qualifies
    for (int t = 0; t < 3; t++) begin
      code = (t == 0) ? 30 : rnd(0, 25);
      lf = code + 10;
      gb = (t == 0) ? 0 : rnd(lf + 1, 41);
      wr_cfg(0, 1'b1, code);
      wr_cfg(1, 1'b1, 31);
      ok_m[0] = '0;
      ok_m[1] = (gb == 0) ? 64'd0 : ((64'd1 << gb) | (64'd1 << lf) | (64'd1 << 10));
      nf = (gb == 0) ? 3 : gb - lf + 2;
      for (int k = 0; k < nf; k++) begin
        run_field(0);
        chk("R7 follow fixed", got_line[1], exp_scan(lf + 1, gb, k));
        chk("R7 upstream still erring", int'(crc_err[0]), 1);
      end
    end
    wr_cfg(0, 1'b0, 0);
    wr_cfg(1, 1'b1, 31);
    ok_m[1] = 64'd1 << 12;
    for (int k = 0; k < 4; k++) begin
      run_field(0);
      chk("R7 disabled upstream", got_line[1], exp_scan(10, 12, k));
    end

    // R6: both readers searching
    for (int t = 0; t < 3; t++) begin
      ga = rnd(11, 30);
      gb = rnd(ga + 1, 41);
      wr_cfg(0, 1'b1, 31);
      wr_cfg(1, 1'b1, 31);
      ok_m[0] = 64'd1 << ga;
      ok_m[1] = (64'd1 << gb) | (64'd1 << ga) | (64'd1 << 10);
      nf = ga - 10 + 1;
      for (int k = 0; k < nf; k++) begin
        run_field(0);
        chk("R6 follower waits", got_cnt[1], 0);
      end
      for (int k = 0; k < gb - ga + 1; k++) begin
        run_field(0);
        chk("R6 follower search", got_line[1], exp_scan(ga + 1, gb, k));
        chk("R6 leader locked", got_line[0], ga);
      end
      chk("R6 follower line", int'(rd_line_b), gb);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule